// File: doc/BRIEF.md
# Two-Bank DRAM Sequencer with CBR Refresh

This block sits between an internal request/acknowledge bus and two banks of asynchronous DRAM that share address, data and write-enable pins. The top bit of the request address picks the bank. Each bank has its own RAS line and its own pair of byte-lane CAS lines. The remaining address bits are cut into a column part and a row part. The column part has a configurable width, and the row part is made of the bits above it. The controller then plays out the strobe sequence: a full precharge, RAS and CAS cycle, or a CAS-only cycle when fast page mode finds the row already open.

A 6-bit interval register and a fixed prescaler raise periodic CAS-before-RAS refresh requests. Holding the self-refresh input high places the devices in self-refresh: the CBR entry cycle is followed by RAS and CAS kept low. Configuration is a set of static inputs: page mode per bank, an extra RAS wait, an extra CAS wait, the column width, the strobe arrangement and the refresh interval.

State machine: `ST_IDLE` waits. `ST_PRE`, `ST_RAS`, optional `ST_RAS_W`, `ST_COL`, `ST_CAS`, optional `ST_CAS_W` and `ST_ACK` form an access. A page hit jumps `ST_IDLE`→`ST_CAS`. A refresh runs `ST_R_CLOSE` (only when a row is open), `ST_R_CAS`, `ST_R_RAS`, then either `ST_R_END` or the self-refresh hold `ST_SELF`, and `ST_SELF` leaves through `ST_R_END` back to `ST_IDLE`. `ST_IDLE` checks refresh or self-refresh first, then a page hit, then a miss into `ST_PRE`. `ST_CAS` goes to `ST_CAS_W` or `ST_ACK`. `ST_R_RAS` goes to `ST_SELF` or `ST_R_END`.

Top module: `dram_ctrl`

## Requirements
- R1: Address bit 21 selects the bank (0 or 1). Only the selected bank's RAS and CAS lines (cas_n[1:0] for bank 0, cas_n[3:2] for bank 1) move during an access. An open row in the other bank stays open.
- R2: With page mode off, an access runs precharge, RAS, column, CAS, acknowledge: ack is seen 5 clock edges after the edge that accepts req. RAS is high again during the ack cycle.
- R3: With page mode on for a bank (cfg_page bit = bank number), the row stays open after the access. A later access to the same row of that bank acknowledges after 2 edges.
- R4: In page mode, an access to a different row than the open one closes the row and runs the full 5-edge sequence.
- R5: cfg_ras_wait adds one cycle to the RAS phase and cfg_cas_wait adds one cycle to the CAS phase. Each adds one edge to the latency, and they add together.
- R6: cfg_col_sel 0,1,2,3 selects a column width of 8, 9, 10 or 12 bits. The column is the low bits of addr[20:0] and the row (12 bits) is the bits above it. Each appears on dram_addr during its phase.
- R7: With cfg_two_we=0, a write asserts the CAS lanes given by req_be (bit0 = low byte) and both WE lines. With cfg_two_we=1, a write asserts both CAS lanes and the WE lines given by req_be. A read asserts both CAS lanes, keeps both WE high and pulls oe_n low.
- R8: With cfg_ref_interval=N>0, a CBR refresh is requested every N*REF_DIV cycles (REF_DIV=4). CAS goes low on all lanes one cycle before RAS goes low on both banks. N=0 stops refresh.
- R9: A pending refresh waits for the access in progress to finish and takes priority over a new request. Open rows are closed before the CBR cycle starts, so the next access to a formerly open row takes the full sequence.
- R10: While cfg_self_ref is high, after the CBR entry all RAS and CAS lines stay low and requests are not acknowledged. After cfg_self_ref falls, one precharge cycle passes and then the held request is served.
- R11: ack is a one-cycle pulse. For a read, rdata holds the word read while ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write |
| req_addr | input | 22 | Word address; bit 21 is the bank |
| req_be | input | 2 | Byte enables for writes |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | Access complete pulse |
| rdata | output | 16 | Read data |
| cfg_page | input | 2 | Page mode per bank |
| cfg_ras_wait | input | 1 | Extra RAS-phase cycle |
| cfg_cas_wait | input | 1 | Extra CAS-phase cycle |
| cfg_col_sel | input | 2 | Column width code |
| cfg_two_we | input | 1 | Strobe arrangement: 0 = two CAS/one WE, 1 = two WE/one CAS |
| cfg_ref_interval | input | 6 | Refresh interval in prescaler ticks, 0 = off |
| cfg_self_ref | input | 1 | Self-refresh request |
| ras_n | output | 2 | RAS per bank |
| cas_n | output | 4 | CAS per bank and byte lane |
| we_n | output | 2 | WE per byte lane |
| oe_n | output | 1 | Output enable |
| dram_addr | output | 12 | Multiplexed row/column address |
| dq_out | output | 16 | Write data to DRAM |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | 16 | Read data from DRAM |

## Verification
Some properties are checked on every cycle. ack is a single-cycle pulse, CAS never reaches both banks outside refresh, WE stays high whenever output enable is low, every CBR begins with RAS high on both banks, and RAS and CAS stay low while self-refresh is held. Other behaviour only the directed scenarios can show: latency counts for normal, page-hit, page-miss and wait-extended accesses, the row/column split for each width code, byte-lane data kept through partial writes in both strobe arrangements, refresh rate against the interval, closing of open pages by refresh, and requests held off during self-refresh.

// File: rtl/dram_pkg.sv
package dram_pkg;
    localparam int NB = 2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_RAS, ST_RAS_W, ST_COL, ST_CAS, ST_CAS_W, ST_ACK,
        ST_R_CLOSE, ST_R_CAS, ST_R_RAS, ST_SELF, ST_R_END
    } st_e;

    function automatic int unsigned col_width(input logic [1:0] sel);
        return (sel == 2'd3) ? 12 : (8 + int'(sel));
    endfunction
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int OFF_W = 21,
    parameter int MA_W  = 12
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       col_sel,
    output logic [MA_W-1:0]  row,
    output logic [MA_W-1:0]  col
);
    logic [OFF_W-1:0] mask;
    always_comb begin
        mask = (OFF_W'(1) << dram_pkg::col_width(col_sel)) - OFF_W'(1);
        col  = MA_W'(off & mask);
        row  = MA_W'(off >> dram_pkg::col_width(col_sel));
    end
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int DIV = 4,
    parameter int IW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval,
    input  logic          take,
    output logic          pend
);
    localparam int PW = $clog2(DIV + 1);
    logic [PW-1:0] presc;
    logic [IW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            if (take) pend <= 1'b0;
            if (interval == '0) begin
                presc <= '0;
                cnt   <= '0;
            end else if (presc == PW'(DIV - 1)) begin
                presc <= '0;
                if (({1'b0, cnt} + 1'b1) >= {1'b0, interval}) begin
                    cnt  <= '0;
                    pend <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dram_strobe_map.sv
module dram_strobe_map (
    input  logic                      cas_phase,
    input  logic                      ref_all,
    input  logic                      bank,
    input  logic                      wr,
    input  logic [1:0]                be,
    input  logic                      two_we,
    output logic [2*dram_pkg::NB-1:0] cas_n,
    output logic [1:0]                we_n
);
    logic [1:0] lanes;
    logic [1:0] we_l;

    always_comb begin
        lanes = 2'b00;
        we_l  = 2'b00;
        if (cas_phase) begin
            if (!wr) begin
                lanes = 2'b11;
            end else if (two_we) begin
                lanes = 2'b11;
                we_l  = be;
            end else begin
                lanes = be;
                we_l  = 2'b11;
            end
        end
    end

    for (genvar g = 0; g < dram_pkg::NB; g++) begin : g_bank
        assign cas_n[2*g +: 2] = ref_all ? 2'b00 :
                                 ((int'(bank) == g) ? ~lanes : 2'b11);
    end
    assign we_n = ~we_l;
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
    parameter int ADDR_W  = 22,
    parameter int MA_W    = 12,
    parameter int DW      = 16,
    parameter int REF_DIV = 4,
    parameter int IW      = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      req_we,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_be,
    input  logic [DW-1:0]             req_wdata,
    output logic                      ack,
    output logic [DW-1:0]             rdata,
    input  logic [dram_pkg::NB-1:0]   cfg_page,
    input  logic                      cfg_ras_wait,
    input  logic                      cfg_cas_wait,
    input  logic [1:0]                cfg_col_sel,
    input  logic                      cfg_two_we,
    input  logic [IW-1:0]             cfg_ref_interval,
    input  logic                      cfg_self_ref,
    output logic [dram_pkg::NB-1:0]   ras_n,
    output logic [2*dram_pkg::NB-1:0] cas_n,
    output logic [1:0]                we_n,
    output logic                      oe_n,
    output logic [MA_W-1:0]           dram_addr,
    output logic [DW-1:0]             dq_out,
    output logic                      dq_oe,
    input  logic [DW-1:0]             dq_in
);
    import dram_pkg::*;
    localparam int OFF_W = ADDR_W - 1;

    st_e st, st_nx;
    logic              l_bank, l_we;
    logic [1:0]        l_be;
    logic [DW-1:0]     l_wd;
    logic [OFF_W-1:0]  l_off;
    logic [MA_W-1:0]   l_row, l_col, req_row, req_col_unused;
    logic [NB-1:0]     ras_act;
    logic [MA_W-1:0]   open_row [NB];
    logic              req_bank, page_hit, ref_pend;
    logic              cas_phase, ref_cas, ref_ras;

    assign req_bank = req_addr[ADDR_W-1];

    dram_addr_split #(.OFF_W(OFF_W), .MA_W(MA_W)) u_req_split (
        .off(req_addr[OFF_W-1:0]), .col_sel(cfg_col_sel),
        .row(req_row), .col(req_col_unused));
    dram_addr_split #(.OFF_W(OFF_W), .MA_W(MA_W)) u_cur_split (
        .off(l_off), .col_sel(cfg_col_sel), .row(l_row), .col(l_col));
    dram_ref_timer #(.DIV(REF_DIV), .IW(IW)) u_timer (
        .clk(clk), .rst_n(rst_n), .interval(cfg_ref_interval),
        .take(st == ST_R_CAS), .pend(ref_pend));

    assign page_hit = cfg_page[req_bank] && ras_act[req_bank] &&
                      (open_row[req_bank] == req_row);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (cfg_self_ref || ref_pend) st_nx = (|ras_act) ? ST_R_CLOSE : ST_R_CAS;
                else if (req)                 st_nx = page_hit ? ST_CAS : ST_PRE;
            end
            ST_PRE:     st_nx = ST_RAS;
            ST_RAS:     st_nx = cfg_ras_wait ? ST_RAS_W : ST_COL;
            ST_RAS_W:   st_nx = ST_COL;
            ST_COL:     st_nx = ST_CAS;
            ST_CAS:     st_nx = cfg_cas_wait ? ST_CAS_W : ST_ACK;
            ST_CAS_W:   st_nx = ST_ACK;
            ST_ACK:     st_nx = ST_IDLE;
            ST_R_CLOSE: st_nx = ST_R_CAS;
            ST_R_CAS:   st_nx = ST_R_RAS;
            ST_R_RAS:   st_nx = cfg_self_ref ? ST_SELF : ST_R_END;
            ST_SELF:    st_nx = cfg_self_ref ? ST_SELF : ST_R_END;
            ST_R_END:   st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // request capture, open-row tracking, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_bank <= 1'b0; l_we <= 1'b0; l_be <= '0; l_wd <= '0; l_off <= '0;
            ras_act <= '0; rdata <= '0;
            for (int b = 0; b < NB; b++) open_row[b] <= '0;
        end else begin
            if (st == ST_IDLE && (st_nx == ST_PRE || st_nx == ST_CAS)) begin
                l_bank <= req_bank;
                l_we   <= req_we;
                l_be   <= req_be;
                l_wd   <= req_wdata;
                l_off  <= req_addr[OFF_W-1:0];
                if (st_nx == ST_PRE) ras_act[req_bank] <= 1'b0;
            end
            if (st == ST_IDLE && st_nx == ST_R_CLOSE) ras_act <= '0;
            if (st == ST_PRE) begin
                ras_act[l_bank]  <= 1'b1;
                open_row[l_bank] <= l_row;
            end
            if ((st == ST_CAS || st == ST_CAS_W) && st_nx == ST_ACK) begin
                if (!l_we) rdata <= dq_in;
                if (!cfg_page[l_bank]) ras_act[l_bank] <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        cas_phase = (st == ST_CAS) || (st == ST_CAS_W);
        ref_cas   = (st == ST_R_CAS) || (st == ST_R_RAS) || (st == ST_SELF);
        ref_ras   = (st == ST_R_RAS) || (st == ST_SELF);
        ack       = (st == ST_ACK);
        ras_n     = ~(ras_act | {NB{ref_ras}});
        oe_n      = ~(cas_phase && !l_we);
        dq_oe     = l_we && (cas_phase || st == ST_COL);
        dq_out    = l_wd;
        if (st == ST_PRE || st == ST_RAS || st == ST_RAS_W) dram_addr = l_row;
        else if (st == ST_COL || cas_phase)                 dram_addr = l_col;
        else                                                dram_addr = '0;
    end

    dram_strobe_map u_strobe (
        .cas_phase(cas_phase), .ref_all(ref_cas), .bank(l_bank), .wr(l_we),
        .be(l_be), .two_we(cfg_two_we), .cas_n(cas_n), .we_n(we_n));
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ack,
    input logic [dram_pkg::NB-1:0]   ras_n,
    input logic [2*dram_pkg::NB-1:0] cas_n,
    input logic [1:0]                we_n,
    input logic                      oe_n,
    input logic                      cfg_self_ref
);
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R11
    AST_ONE_BANK_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (|cas_n) |-> $onehot0({~&cas_n[3:2], ~&cas_n[1:0]})); // R1
    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (&we_n)); // R7
    AST_CBR_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cas_n == '0) && (&ras_n)) |-> $past(&ras_n)); // R9
    AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_self_ref && (ras_n == '0) && (cas_n == '0)) |=> ((ras_n == '0) && !ack)); // R10
endmodule

bind dram_ctrl dram_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .cfg_self_ref(cfg_self_ref));

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, req, req_we, ack, cfg_ras_wait, cfg_cas_wait, cfg_two_we, cfg_self_ref;
    logic oe_n, dq_oe;
    logic [21:0] req_addr;
    logic [1:0]  req_be, cfg_page, cfg_col_sel, ras_n, we_n;
    logic [15:0] req_wdata, rdata, dq_out, dq_in;
    logic [5:0]  cfg_ref_interval;
    logic [3:0]  cas_n;
    logic [11:0] dram_addr;

    dram_ctrl uut (.*);

    int total = 0, bad = 0;
    int cbr_cnt = 0;
    logic [1:0]  prev_ras = 2'b11;
    logic [11:0] row_l [2];
    logic [11:0] col_seen, row_seen;
    logic [1:0]  lanes_seen, we_seen;
    logic [15:0] mem [int];

    // behavioural DRAM
    always @(negedge clk) begin
        if (rst_n) begin
            if ((&prev_ras) && (ras_n == 2'b00) && (cas_n == 4'b0000)) cbr_cnt++;
            for (int b = 0; b < 2; b++) begin
                if (prev_ras[b] && !ras_n[b] && (&cas_n[2*b +: 2])) row_l[b] = dram_addr;
                if ((cas_n != 4'b0000) && !(&cas_n[2*b +: 2]) && !ras_n[b]) begin
                    int key;
                    logic [15:0] w;
                    key = (b << 24) | (int'(row_l[b]) << 12) | int'(dram_addr);
                    col_seen = dram_addr;
                    row_seen = row_l[b];
                    lanes_seen |= ~cas_n[2*b +: 2];
                    we_seen |= ~we_n;
                    w = mem.exists(key) ? mem[key] : 16'h0;
                    if (!cas_n[2*b] && !we_n[0]) w[7:0] = dq_out[7:0];
                    if (!cas_n[2*b+1] && !we_n[1]) w[15:8] = dq_out[15:8];
                    if (!(&we_n)) mem[key] = w;
                    if (!oe_n) dq_in = w;
                end
            end
        end
        prev_ras = ras_n;
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [21:0] a, input logic [1:0] be,
                       input logic [15:0] wd, output logic [15:0] rd, output int cyc);
        @(negedge clk);
        req = 1'b1; req_we = wr; req_addr = a; req_be = be; req_wdata = wd;
        lanes_seen = 2'b00; we_seen = 2'b00; cyc = 0;
        forever begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (ack) break;
            if (cyc > 60) begin chk("ack timeout", 0, 1); break; end
        end
        rd = rdata;
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 reset ras_n", ras_n, 2'b11);
        chk("R7 reset cas_n", cas_n, 4'hF);
        chk("R11 reset ack", ack, 0);
    endtask

    task automatic t_normal();
        logic [15:0] d; int c;
        cfg_page = 2'b00;
        acc(1, 22'h000105, 2'b11, 16'h1234, d, c);
        chk("R2 write latency", c, 5);
        chk("R2 ras high after", ras_n, 2'b11);
        acc(0, 22'h000105, 2'b11, 16'h0, d, c);
        chk("R2 read latency", c, 5);
        chk("R11 read data", d, 16'h1234);
        @(negedge clk);
        chk("R11 ack pulse", ack, 0);
    endtask

    task automatic t_page();
        logic [15:0] d; int c;
        cfg_page = 2'b11;
        acc(1, 22'h000210, 2'b11, 16'hBEEF, d, c);
        chk("R3 first access latency", c, 5);
        chk("R3 row held open", ras_n[0], 0);
        acc(1, 22'h000211, 2'b11, 16'hCAFE, d, c);
        chk("R3 page hit latency", c, 2);
        acc(1, 22'h200310, 2'b11, 16'h7777, d, c);
        chk("R1 other bank latency", c, 5);
        chk("R1 both rows open", ras_n, 2'b00);
        acc(0, 22'h000210, 2'b11, 16'h0, d, c);
        chk("R1 bank0 still hit", c, 2);
        chk("R3 hit data", d, 16'hBEEF);
        acc(0, 22'h200310, 2'b11, 16'h0, d, c);
        chk("R1 bank1 data", d, 16'h7777);
    endtask

    task automatic t_miss();
        logic [15:0] d; int c;
        acc(0, 22'h000500, 2'b11, 16'h0, d, c);
        chk("R4 miss latency", c, 5);
        acc(0, 22'h000211, 2'b11, 16'h0, d, c);
        chk("R4 back to old row latency", c, 5);
        chk("R4 old row data", d, 16'hCAFE);
        cfg_page = 2'b00;
    endtask

    task automatic t_wait();
        logic [15:0] d; int c;
        cfg_ras_wait = 1;
        acc(0, 22'h000105, 2'b11, 16'h0, d, c);
        chk("R5 ras wait latency", c, 6);
        cfg_cas_wait = 1;
        acc(0, 22'h000105, 2'b11, 16'h0, d, c);
        chk("R5 both waits latency", c, 7);
        chk("R5 data with waits", d, 16'h1234);
        cfg_ras_wait = 0;
        cfg_page = 2'b01;
        acc(0, 22'h000105, 2'b11, 16'h0, d, c);
        acc(0, 22'h000105, 2'b11, 16'h0, d, c);
        chk("R5 page hit with cas wait", c, 3);
        cfg_cas_wait = 0;
        cfg_page = 2'b00;
    endtask

    task automatic t_colw();
        logic [15:0] d; int c;
        for (int s = 0; s < 4; s++) begin
            int w;
            w = (s == 3) ? 12 : 8 + s;
            cfg_col_sel = 2'(s);
            acc(1, 22'h012345, 2'b11, 16'h4242, d, c);
            chk($sformatf("R6 column sel%0d", s), col_seen, (32'h12345 & ((1 << w) - 1)));
            chk($sformatf("R6 row sel%0d", s), row_seen, ((32'h12345 >> w) & 32'hFFF));
        end
        cfg_col_sel = 2'd0;
    endtask

    task automatic t_strobe();
        logic [15:0] d; int c;
        cfg_two_we = 0;
        acc(1, 22'h000777, 2'b11, 16'hAAAA, d, c);
        acc(1, 22'h000777, 2'b01, 16'h0055, d, c);
        chk("R7 two-CAS lanes", lanes_seen, 2'b01);
        chk("R7 two-CAS we", we_seen, 2'b11);
        cfg_two_we = 1;
        acc(1, 22'h000777, 2'b10, 16'h3300, d, c);
        chk("R7 two-WE lanes", lanes_seen, 2'b11);
        chk("R7 two-WE we", we_seen, 2'b10);
        acc(0, 22'h000777, 2'b00, 16'h0, d, c);
        chk("R7 read lanes", lanes_seen, 2'b11);
        chk("R7 read we idle", we_seen, 2'b00);
        chk("R7 merged bytes", d, 16'h3355);
        cfg_two_we = 0;
    endtask

    task automatic t_refresh();
        int n;
        n = cbr_cnt;
        cfg_ref_interval = 6'd5;
        idle(200);
        chk("R8 refresh count", ((cbr_cnt - n) >= 9) && ((cbr_cnt - n) <= 11), 1);
        cfg_ref_interval = 6'd0;
        idle(10);
        n = cbr_cnt;
        idle(100);
        chk("R8 refresh disabled", cbr_cnt - n, 0);
    endtask

    task automatic t_ref_prio();
        logic [15:0] d; int c, n;
        cfg_page = 2'b01;
        acc(1, 22'h000900, 2'b11, 16'h0900, d, c);
        n = cbr_cnt;
        cfg_ref_interval = 6'd5;
        idle(30);
        chk("R9 refresh ran", cbr_cnt > n, 1);
        chk("R9 page closed", ras_n[0], 1);
        acc(0, 22'h000900, 2'b11, 16'h0, d, c);
        chk("R9 reopen latency", c, 5);
        chk("R9 data after refresh", d, 16'h0900);
        for (int i = 0; i < 8; i++) acc(1, 22'h000A00 + 22'(i * 64), 2'b11, 16'(16'hA0 + i), d, c);
        for (int i = 0; i < 8; i++) begin
            acc(0, 22'h000A00 + 22'(i * 64), 2'b11, 16'h0, d, c);
            chk("R9 data with refresh traffic", d, 16'(16'hA0 + i));
        end
        cfg_ref_interval = 6'd0;
        cfg_page = 2'b00;
        idle(10);
    endtask

    task automatic t_self();
        logic [15:0] d; int c, n, acks;
        acc(1, 22'h000333, 2'b11, 16'h5A5A, d, c);
        n = cbr_cnt;
        cfg_self_ref = 1;
        idle(5);
        chk("R10 entry CBR", cbr_cnt - n, 1);
        chk("R10 ras held", ras_n, 2'b00);
        chk("R10 cas held", cas_n, 4'h0);
        req = 1; req_we = 0; req_addr = 22'h000333; req_be = 2'b11;
        acks = 0;
        repeat (10) begin @(negedge clk); if (ack) acks++; end
        chk("R10 requests ignored", acks, 0);
        cfg_self_ref = 0;
        c = 0;
        forever begin
            @(negedge clk); c++;
            if (ack || c > 30) break;
        end
        chk("R10 served after exit", ack, 1);
        chk("R10 data after exit", rdata, 16'h5A5A);
        req = 0;
        idle(2);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; req = 0; req_we = 0; req_addr = '0; req_be = '0; req_wdata = '0;
        cfg_page = 0; cfg_ras_wait = 0; cfg_cas_wait = 0; cfg_col_sel = 0;
        cfg_two_we = 0; cfg_ref_interval = 0; cfg_self_ref = 0; dq_in = '0;
        row_l[0] = '0; row_l[1] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        idle(2);
        t_normal();
        t_page();
        t_miss();
        t_wait();
        t_colw();
        t_strobe();
        t_refresh();
        t_ref_prio();
        t_self();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule